// File: doc/BRIEF.md
# UART Extended-Configuration Bank with Write Lock

This block stores the extended configuration fields of a UART, and one unlock bit that decides whether those fields can be changed. The extended fields are scattered across several host registers: the upper interrupt-enable bits, the upper FIFO-control bits, the upper modem-control bits, two status-select bits and a 4-bit fractional divisor. The other bits of the same registers are base fields. Software that predates the extended features can keep writing whole registers without disturbing extended settings that were locked earlier.

The host uses a single-cycle write port and a combinational read port that share one address. When the unlock bit is clear, a write to a register updates only its base bits, and the extended bits keep their stored values. When the unlock bit is set, every stored bit can be written. The extended fields are also presented on dedicated outputs for the rest of the UART.

Top module: `ewp_bank`

## Requirements
- R1: After reset every stored bit is 0, the unlock bit included, so the extended fields start out locked and hold 0.
- R2: While the unlock bit is 0, a write leaves the protected bits unchanged. The protected bits are: address 0 bits 7:4, address 1 bits 5:4, address 2 bits 7:5, address 3 bits 5:4, and address 4 bits 3:0.
- R3: While the unlock bit is 1, a write stores every implemented bit of the addressed register from wdata.
- R4: Unprotected bits of addresses 0 to 3 take the written value whatever the state of the unlock bit. A single write can therefore change base bits while the protected bits of the same register keep their old value.
- R5: The unlock bit is bit 4 of address 5. All eight bits of address 5 are always writable. A new unlock value governs writes from the following cycle onward.
- R6: rdata returns, in the same cycle, the value stored at the presented address. Addresses 6 and 7 read as 0, and a write to them changes no stored bit.
- R7: The fractional divisor at address 4 is 4 bits wide and sits in bits 3:0. Bits 7:4 of address 4 always read 0.
- R8: The dedicated outputs always equal the stored fields: ier_ext = addr0[7:4], fcr_ext = addr1[5:4], mcr_ext = addr2[7:5], isr_ext = addr3[5:4], frac_div = addr4[3:0], enh_en = addr5[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Stored value at addr, combinational |
| ier_ext | output | 4 | Extended interrupt-enable field |
| fcr_ext | output | 2 | Extended FIFO-control field |
| mcr_ext | output | 3 | Extended modem-control field |
| isr_ext | output | 2 | Extended status-select field |
| frac_div | output | 4 | Fractional divisor |
| enh_en | output | 1 | Unlock bit |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 3-bit address and a 4-bit fraction. At this size the whole space can be swept. Every one of the 256 data values is written to every address, once with the bank locked and once with it unlocked, and all readback values and field outputs are checked after each write. The unlock register is then swept as well, so the unlock bit toggles between writes. This reaches the case where clearing the bit locks the very next write, and the unmapped addresses are covered too.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

    localparam int NUM_REGS   = 6;
    localparam int UNLOCK_REG = 5;
    localparam int UNLOCK_BIT = 4;

    // Bits that exist in each register (unimplemented bits read 0).
    function automatic logic [7:0] store_mask(input int idx, input int frac_w);
        logic [7:0] m;
        m = 8'hFF;
        if (idx == 4) m = 8'((1 << frac_w) - 1);
        return m;
    endfunction

    // Bits that only change while the unlock bit is set.
    function automatic logic [7:0] prot_mask(input int idx, input int frac_w);
        logic [7:0] m;
        case (idx)
            0:       m = 8'hF0;
            1:       m = 8'h30;
            2:       m = 8'hE0;
            3:       m = 8'h30;
            4:       m = 8'((1 << frac_w) - 1);
            default: m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ewp_decode.sv
module ewp_decode #(
    parameter int ADDR_W   = 3,
    parameter int NUM_REGS = 6
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (addr == ADDR_W'(i))) sel[i] = 1'b1;
        end
    end
endmodule

// File: rtl/ewp_reg.sv
module ewp_reg #(
    parameter int         W          = 8,
    parameter logic [7:0] STORE_MASK = 8'hFF,
    parameter logic [7:0] PROT_MASK  = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         unlock,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] STORE = W'(STORE_MASK);
    localparam logic [W-1:0] PROT  = W'(PROT_MASK);

    typedef struct packed {
        logic [W-1:0] val;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [W-1:0] wmask;

    always_comb begin
        st_d  = st_q;
        wmask = unlock ? STORE : (STORE & ~PROT);
        if (we) st_d.val = (st_q.val & ~wmask) | (wdata & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/ewp_readmux.sv
module ewp_readmux #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 6
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_REGS*DATA_W-1:0] flat,
    output logic [DATA_W-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) rdata = flat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/ewp_bank.sv
module ewp_bank
    import ewp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [3:0]        ier_ext,
    output logic [1:0]        fcr_ext,
    output logic [2:0]        mcr_ext,
    output logic [1:0]        isr_ext,
    output logic [FRAC_W-1:0] frac_div,
    output logic              enh_en
);
    localparam int FLAT_W = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] sel;
    logic [FLAT_W-1:0]   flat;
    logic                unlock;

    ewp_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (sel)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        ewp_reg #(
            .W          (DATA_W),
            .STORE_MASK (store_mask(g, FRAC_W)),
            .PROT_MASK  (prot_mask(g, FRAC_W))
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (sel[g]),
            .unlock (unlock),
            .wdata  (wdata),
            .q      (flat[g*DATA_W +: DATA_W])
        );
    end

    assign unlock = flat[UNLOCK_REG*DATA_W + UNLOCK_BIT];

    ewp_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
        .addr  (addr),
        .flat  (flat),
        .rdata (rdata)
    );

    assign ier_ext  = flat[0*DATA_W + 4 +: 4];
    assign fcr_ext  = flat[1*DATA_W + 4 +: 2];
    assign mcr_ext  = flat[2*DATA_W + 5 +: 3];
    assign isr_ext  = flat[3*DATA_W + 4 +: 2];
    assign frac_div = flat[4*DATA_W +: FRAC_W];
    assign enh_en   = unlock;
endmodule

// File: rtl/ewp_bank_chk.sv
module ewp_bank_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [3:0]        ier_ext,
    input logic [1:0]        fcr_ext,
    input logic [2:0]        mcr_ext,
    input logic [1:0]        isr_ext,
    input logic [FRAC_W-1:0] frac_div,
    input logic              enh_en
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (enh_en == 1'b0 && ier_ext == '0 && frac_div == '0));

    p_locked_ier_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && !enh_en) |=> $stable(ier_ext));

    p_locked_mcr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2) && !enh_en) |=> $stable(mcr_ext));

    p_locked_frac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4) && !enh_en) |=> $stable(frac_div));

    p_open_ier_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && enh_en) |=> (ier_ext == $past(wdata[7:4])));

    p_unlock_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(5)) |=> (enh_en == $past(wdata[4])));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ier_ext) && $stable(fcr_ext) && $stable(mcr_ext)
                    && $stable(isr_ext) && $stable(frac_div) && $stable(enh_en)));

    p_frac_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(4)) |-> (rdata[DATA_W-1:FRAC_W] == '0));
endmodule

bind ewp_bank ewp_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ier_ext(ier_ext), .fcr_ext(fcr_ext), .mcr_ext(mcr_ext),
    .isr_ext(isr_ext), .frac_div(frac_div), .enh_en(enh_en)
);

// File: tb/tb_ewp_bank.sv
module tb_ewp_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] ier_ext;
    logic [1:0] fcr_ext;
    logic [2:0] mcr_ext;
    logic [1:0] isr_ext;
    logic [3:0] frac_div;
    logic       enh_en;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    logic [7:0] mdl [6];

    always #10 clk = ~clk;

    ewp_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ier_ext(ier_ext), .fcr_ext(fcr_ext), .mcr_ext(mcr_ext),
        .isr_ext(isr_ext), .frac_div(frac_div), .enh_en(enh_en)
    );

    function automatic logic [7:0] impl_bits(int a);
        return (a == 4) ? 8'h0F : (a < 6 ? 8'hFF : 8'h00);
    endfunction

    function automatic logic [7:0] lock_bits(int a);
        case (a)
            0: return 8'hF0;
            1: return 8'h30;
            2: return 8'hE0;
            3: return 8'h30;
            4: return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R6 R7: model update applied with the unlock state before the write
    task automatic wr(int a, logic [7:0] d);
        logic [7:0] m;
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 6) begin
            m = mdl[5][4] ? impl_bits(a) : (impl_bits(a) & ~lock_bits(a));
            mdl[a] = (mdl[a] & ~m) | (d & m);
        end
    endtask

    task automatic check_all(string req);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #1;
            check(req, rdata, (a < 6) ? mdl[a] : 8'h00);
        end
        // R8: field outputs
        check("R8", {ier_ext, fcr_ext, mcr_ext, isr_ext, frac_div, enh_en},
              {mdl[0][7:4], mdl[1][5:4], mdl[2][7:5], mdl[3][5:4], mdl[4][3:0], mdl[5][4]});
    endtask

    initial begin
        for (int i = 0; i < 6; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // Locked then unlocked sweep of every data value on every address
        for (int pass = 0; pass < 2; pass++) begin
            wr(5, pass ? 8'h10 : 8'h00);
            check("R5", {31'd0, enh_en}, 32'(pass));
            for (int a = 0; a < 8; a++) begin
                if (a == 5) continue;
                for (int d = 0; d < 256; d++) begin
                    wr(a, 8'(d));
                    addr = 3'(a);
                    #1;
                    check(pass ? "R3" : (a >= 6 ? "R6" : "R2_R4"),
                          rdata, (a < 6) ? mdl[a] : 8'h00);
                    if (a == 4) check("R7", {24'd0, rdata[7:4]}, 32'd0);
                end
                check_all("R6");
            end
        end

        // Unlock register sweep: bit 4 toggles, protected writes follow each change
        for (int d = 0; d < 256; d++) begin
            wr(5, 8'(d));
            wr(0, 8'(~d));
            wr(2, 8'(d * 7));
            check_all("R5");
        end

        // Clearing unlock locks the very next write (R5, R2)
        wr(5, 8'h10);
        wr(0, 8'hA5);
        wr(5, 8'h00);
        wr(0, 8'h3C);
        check_all("R5");
        check("R2", {28'd0, ier_ext}, 32'hA);
        check("R4", {24'd0, mdl[0]}, 32'hAC);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                vectors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule